// File: doc/BRIEF.md
# Oscillator Trim Register with Fuse Reload

This block holds the trim code for an on-chip oscillator and a sticky flag that records that the trim came from the fuse array. A short sequencer runs after every reset. It looks at the reset type and at the flag, and decides whether the trim must be fetched again from the fuses. If a fetch is needed, it raises a request and waits for the fuse controller to answer with a valid strobe. The CPU start enable stays low until that fetch has landed and the flag is set.

Software may replace the trim later through a simple write port. Each such write must be preceded by an unlock write that carries a key byte and the trim register offset. Any write to the trim register that lacks a preceding unlock changes nothing and raises a one-cycle protection error. A combinational read port returns the trim code and the flag.

Top module: `osc_trim_ctrl`

## Requirements
- R1: While `por_rst` is high, and after its release until a fetch completes: `trim` is 0, `loaded` is 0, `cpu_start_en` is 0 and `prot_err` is 0.
- R2: After `por_rst` is released, `fuse_req` is high from the first clock edge that follows. It stays high until an edge at which `fuse_vld` is high. At that edge `trim` takes `fuse_trim`, `loaded` becomes 1 and `fuse_req` drops.
- R3: A `sys_rst` pulse taken while `loaded` is 0 starts the fetch of R2 again. This holds also when the pulse interrupts a fetch already in progress.
- R4: A `sys_rst` pulse taken while `loaded` is 1 keeps `trim` and `loaded` unchanged and never raises `fuse_req`. In this case `cpu_start_en` rises at the first edge after `sys_rst` falls.
- R5: `cpu_start_en` is 0 during any reset and stays 0 until the fetch, if one is needed, has completed with `loaded` equal to 1.
- R6: Only `por_rst` clears `loaded`. No write on the register port changes it.
- R7: A write to offset 0x00 arms the trim register only when its data carries key 0xA5 in bits [31:24] and the trim offset 0x04 in bits [7:0]. Any other data at that offset leaves the register disarmed.
- R8: A write to offset 0x04 while the register is armed loads data bits [7:0] into `trim` at that edge. The arm is used up by the next write of any offset.
- R9: A write to offset 0x04 while the register is not armed leaves `trim` unchanged. `prot_err` is then high for exactly the cycle after that write.
- R10: Writes presented while `cpu_start_en` is 0 have no effect and raise no `prot_err`.
- R11: When `rd_addr` is 0x04, `rd_data` shows `trim` in bits [7:0] and `loaded` in bit 16, with every other bit 0. Any other `rd_addr` reads 0. The read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | Any other reset, synchronous, active high |
| fuse_req | output | 1 | Request to the fuse controller for the trim code |
| fuse_vld | input | 1 | The fuse controller presents valid data on `fuse_trim` |
| fuse_trim | input | 8 | Trim code read from the fuses |
| cpu_start_en | output | 1 | Allows the CPU to start fetching instructions |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data, combinational |
| prot_err | output | 1 | One-cycle pulse after a write that was not unlocked |
| trim | output | 8 | Trim code sent to the oscillator |
| loaded | output | 1 | Sticky flag: the trim has been fetched from the fuses |

## Verification
Every registered result is due one edge after its cause. The trim code, the flag and the drop of `fuse_req` follow the edge at which `fuse_vld` is seen. `prot_err` follows the edge at which the unprotected write is taken. `cpu_start_en` rises one edge after a reset that needs no fetch, and on the edge that accepts the fuse data otherwise. `rd_data` is due in the same cycle as `rd_addr`. The bench changes inputs 1 ns after a rising edge, lets one edge pass, and compares outputs 1 ns after that edge against a reference model that it updates with the inputs it drove.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int TRIM_W   = 8;
    localparam int KEY_W    = 8;
    localparam int FLAG_POS = 16;

    localparam logic [KEY_W-1:0]  UNLOCK_KEY = 8'hA5;
    localparam logic [ADDR_W-1:0] UNLOCK_OFS = 8'h00;
    localparam logic [ADDR_W-1:0] TRIM_OFS   = 8'h04;

    typedef enum logic [1:0] {
        SEQ_CHECK = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    // key byte on top, target offset in the low byte
    function automatic logic key_matches(logic [DATA_W-1:0] d, logic [ADDR_W-1:0] target);
        return (d[DATA_W-1 -: KEY_W] == UNLOCK_KEY) && (d[ADDR_W-1:0] == target);
    endfunction

endpackage

// File: rtl/otc_reload_seq.sv
module otc_reload_seq
    import osc_trim_pkg::*;
(
    input  logic clk,
    input  logic por_rst,
    input  logic sys_rst,
    input  logic loaded_i,
    input  logic fuse_vld,
    output logic fuse_req,
    output logic fuse_take,
    output logic run
);

    seq_state_e state_q;
    logic       any_rst;

    assign any_rst = por_rst | sys_rst;

    always_ff @(posedge clk) begin
        if (any_rst) begin
            state_q <= SEQ_CHECK;
        end else begin
            unique case (state_q)
                SEQ_CHECK: state_q <= loaded_i ? SEQ_RUN : SEQ_FETCH;
                SEQ_FETCH: if (fuse_vld) state_q <= SEQ_RUN;
                SEQ_RUN:   state_q <= SEQ_RUN;
                default:   state_q <= SEQ_CHECK;
            endcase
        end
    end

    assign fuse_req  = (state_q == SEQ_FETCH);
    assign fuse_take = fuse_req && fuse_vld && !any_rst;
    assign run       = (state_q == SEQ_RUN) && !any_rst;

    // R2
    fuse_req_held_chk: assert property (@(posedge clk) disable iff (any_rst)
        (fuse_req && !fuse_vld) |=> fuse_req);

    // R5
    run_excludes_req_chk: assert property (@(posedge clk) disable iff (any_rst)
        fuse_take |=> run);

endmodule

// File: rtl/otc_unlock_gate.sv
module otc_unlock_gate
    import osc_trim_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  bus_wr_t wr,
    output logic    accept,
    output logic    prot_err
);

    logic armed_q;
    logic live_wr;
    logic hits_unlock;
    logic hits_trim;

    assign live_wr     = wr.en && enable;
    assign hits_unlock = live_wr && (wr.addr == UNLOCK_OFS);
    assign hits_trim   = live_wr && (wr.addr == TRIM_OFS);
    assign accept      = hits_trim && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            prot_err <= 1'b0;
        end else begin
            prot_err <= hits_trim && !armed_q;
            if (live_wr) begin
                armed_q <= hits_unlock && key_matches(wr.data, TRIM_OFS);
            end
        end
    end

    // R9
    err_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        prot_err |-> $past(wr.en));

    // R8
    arm_used_once_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);

endmodule

// File: rtl/otc_readback.sv
module otc_readback
    import osc_trim_pkg::*;
#(
    parameter int TW = TRIM_W
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [TW-1:0]     trim_i,
    input  logic              flag_i,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        if (rd_addr == TRIM_OFS) begin
            rd_data[TW-1:0]    = trim_i;
            rd_data[FLAG_POS]  = flag_i;
        end
    end

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
    import osc_trim_pkg::*;
(
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    output logic              fuse_req,
    input  logic              fuse_vld,
    input  logic [TRIM_W-1:0] fuse_trim,
    output logic              cpu_start_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              prot_err,
    output logic [TRIM_W-1:0] trim,
    output logic              loaded
);

    logic [TRIM_W-1:0] trim_q;
    logic              loaded_q;
    logic              take;
    logic              run;
    logic              accept;
    bus_wr_t           bus;

    assign bus = '{en: wr_en, addr: wr_addr, data: wr_data};

    otc_reload_seq u_seq (
        .clk      (clk),
        .por_rst  (por_rst),
        .sys_rst  (sys_rst),
        .loaded_i (loaded_q),
        .fuse_vld (fuse_vld),
        .fuse_req (fuse_req),
        .fuse_take(take),
        .run      (run)
    );

    otc_unlock_gate u_gate (
        .clk     (clk),
        .rst     (por_rst | sys_rst),
        .enable  (run),
        .wr      (bus),
        .accept  (accept),
        .prot_err(prot_err)
    );

    otc_readback #(.TW(TRIM_W)) u_rd (
        .rd_addr(rd_addr),
        .trim_i (trim_q),
        .flag_i (loaded_q),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (por_rst) begin
            trim_q   <= '0;
            loaded_q <= 1'b0;
        end else if (take) begin
            trim_q   <= fuse_trim;
            loaded_q <= 1'b1;
        end else if (accept) begin
            trim_q   <= wr_data[TRIM_W-1:0];
        end
    end

    assign trim         = trim_q;
    assign loaded       = loaded_q;
    assign cpu_start_en = run;

    // R5
    start_needs_flag_chk: assert property (@(posedge clk) disable iff (por_rst)
        cpu_start_en |-> loaded_q);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (por_rst)
        !$fell(loaded_q));

    // R8
    trim_guarded_chk: assert property (@(posedge clk) disable iff (por_rst)
        (!$past(take) && !$past(accept) && !$past(por_rst)) |-> $stable(trim_q));

endmodule

// File: tb/osc_trim_ctrl_bench.sv
module osc_trim_ctrl_bench;
    import osc_trim_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              por_rst = 1'b1, sys_rst = 1'b0;
    logic              fuse_req, fuse_vld = 1'b0;
    logic [TRIM_W-1:0] fuse_trim = '0;
    logic              cpu_start_en;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = 8'h04;
    logic [DATA_W-1:0] wr_data = '0, rd_data;
    logic              prot_err, loaded;
    logic [TRIM_W-1:0] trim;

    int tests = 0, fails = 0;

    logic [TRIM_W-1:0] m_trim;
    logic              m_loaded, m_arm, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_trim_ctrl u_osc_trim_ctrl (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
        .fuse_req(fuse_req), .fuse_vld(fuse_vld), .fuse_trim(fuse_trim),
        .cpu_start_en(cpu_start_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .prot_err(prot_err), .trim(trim), .loaded(loaded)
    );

    function automatic logic [31:0] exp_rd(logic [7:0] a, logic [7:0] t, logic f);
        logic [31:0] r = '0;
        if (a == 8'h04) begin r[7:0] = t; r[16] = f; end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check_all(string req);
        chk({req, " trim"}, 32'(trim), 32'(m_trim));
        chk({req, " loaded"}, 32'(loaded), 32'(m_loaded));
        chk({req, " prot_err"}, 32'(prot_err), 32'(m_err));
        chk({req, " rd_data"}, rd_data, exp_rd(rd_addr, m_trim, m_loaded));
    endtask

    // model of one write taken at the next edge while running
    task automatic bus_write(string req, logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        m_err = 1'b0;
        if (a == 8'h04) begin
            if (m_arm) m_trim = d[7:0]; else m_err = 1'b1;
        end
        m_arm = (a == 8'h00) && (d[31:24] == 8'hA5) && (d[7:0] == 8'h04);
        tick();
        wr_en = 1'b0;
        check_all(req);
    endtask

    task automatic idle(string req);
        m_err = 1'b0;
        tick();
        check_all(req);
    endtask

    task automatic fetch(string req, logic [7:0] v, int waitc);
        for (int i = 0; i < waitc; i++) begin
            tick();
            chk({req, " req held"}, 32'(fuse_req), 32'd1);
            chk("R5 start low during fetch", 32'(cpu_start_en), 32'd0);
        end
        fuse_vld = 1'b1; fuse_trim = v;
        tick();
        fuse_vld = 1'b0;
        m_trim = v; m_loaded = 1'b1; m_arm = 1'b0; m_err = 1'b0;
        chk({req, " req drop"}, 32'(fuse_req), 32'd0);
        chk("R5 start after fetch", 32'(cpu_start_en), 32'd1);
        check_all(req);
    endtask

    task automatic do_por();
        por_rst = 1'b1;
        repeat (3) tick();
        m_trim = '0; m_loaded = 1'b0; m_arm = 1'b0; m_err = 1'b0;
        chk("R1 start in por", 32'(cpu_start_en), 32'd0);
        check_all("R1 por");
        por_rst = 1'b0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        tick();
        do_por();
        chk("R2 req after por", 32'(fuse_req), 32'd1);
        check_all("R1 after release");
        // R10: writes during fetch do nothing
        wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'hA500_0004; tick();
        wr_addr = 8'h04; wr_data = 32'h0000_0033; tick();
        wr_en = 1'b0; tick();
        check_all("R10 busy write");
        fetch("R2 fetch", 8'h5A, 2);

        bus_write("R9 unlocked-less write", 8'h04, 32'h0000_0011);
        idle("R9 err one cycle");
        bus_write("R7 unlock", 8'h00, 32'hA500_0004);
        bus_write("R8 armed write", 8'h04, 32'h0000_0077);
        bus_write("R8 second write", 8'h04, 32'h0000_0088);
        bus_write("R7 bad key", 8'h00, 32'hA400_0004);
        bus_write("R7 bad key write", 8'h04, 32'h0000_0099);
        bus_write("R7 bad target", 8'h00, 32'hA500_0008);
        bus_write("R7 bad target write", 8'h04, 32'h0000_0099);
        bus_write("R8 unlock", 8'h00, 32'hA500_0004);
        bus_write("R8 other offset", 8'h08, 32'h0000_0001);
        bus_write("R8 consumed write", 8'h04, 32'h0000_0066);
        bus_write("R6 unlock", 8'h00, 32'hA500_0004);
        bus_write("R6 flag not writable", 8'h04, 32'h0000_0042);
        rd_addr = 8'h10; #1;
        chk("R11 other read", rd_data, 32'd0);
        rd_addr = 8'h04; #1;
        chk("R11 trim read", rd_data, exp_rd(8'h04, m_trim, m_loaded));

        // R4: sys reset with flag set
        sys_rst = 1'b1; tick();
        chk("R4 start low in reset", 32'(cpu_start_en), 32'd0);
        sys_rst = 1'b0; tick();
        chk("R4 no req", 32'(fuse_req), 32'd0);
        chk("R4 start", 32'(cpu_start_en), 32'd1);
        m_arm = 1'b0; m_err = 1'b0;
        check_all("R4 kept");

        // R3: por then sys reset mid fetch
        do_por();
        tick();
        sys_rst = 1'b1; tick(); sys_rst = 1'b0; tick();
        chk("R3 req again", 32'(fuse_req), 32'd1);
        check_all("R3 state");
        fetch("R3 fetch", 8'hC3, 1);

        for (int n = 0; n < 400; n++) begin
            int unsigned op = $urandom % 6;
            logic [7:0] v = 8'($urandom);
            rd_addr = ($urandom % 4 == 0) ? 8'h0C : 8'h04;
            case (op)
                0: bus_write("R7 rnd unlock", 8'h00, 32'hA500_0004);
                1: bus_write("R7 rnd bad", 8'h00, {8'($urandom), 16'h0, v});
                2, 3: bus_write("R8 rnd trim", 8'h04, {24'($urandom), v});
                4: bus_write("R8 rnd other", 8'h08, 32'($urandom));
                default: idle("R11 rnd idle");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule